// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the four upper flags of an I2C controller's primary status byte: a summary event flag, a flag saying the master has put out the header of a 10-bit address, a transfer direction flag, and a bus-activity flag. The bus engine feeds it single-cycle pulses for each event it sees. The register interface feeds it strobes for a read of the secondary status register, a write of the data register, and any other register access. A peripheral-enable level gates three of the four flags.

Every flag is a register, so it changes in the clock cycle after the pulse or strobe that causes the change. The flags clear in different ways. The event flag has two clear paths, chosen by whether an error event is pending. The header flag needs a two-step software sequence. The direction flag follows the engine's byte-done state and some bus events. The busy flag depends only on start and stop detection.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset, status_o reads 8'h00 and all four flag outputs are 0.
- R2: status_o carries the event flag on bit 7, the header flag on bit 6, the direction flag on bit 5 and the busy flag on bit 4. Bits 3 to 0 always read 0.
- R3: With enable high, the event flag is 1 in the cycle after any of these pulses: byte done, address match while ack_en_i is 1, start generated, ack failure, slave stop, arbitration lost, bus error, header sent. An address match while ack_en_i is 0 does not set it.
- R4: Ack failure, slave stop, arbitration lost and bus error mark an error as pending. While an error is pending, a secondary-status read clears the event flag and the pending mark. While no error is pending, a data-register write clears the event flag.
- R5: The header flag is set by the header-sent pulse. A secondary-status read arms the clear. The next data-register write clears the flag, if no other register access comes between the read and the write. Any other access disarms the clear.
- R6: On a byte-done pulse, the direction flag takes the value of btf_tx_i (1 = transmitted, 0 = received). It is cleared by the byte-done-cleared pulse, by the slave-stop pulse and by the arbitration-lost pulse.
- R7: The busy flag is set by start detection. It is cleared by stop detection or by a bus error. The enable input has no effect on it.
- R8: While pe_i is 0, the event, header and direction flags read 0 in the next cycle and their set pulses are ignored. A pending error and an armed header clear are dropped.
- R9: When a set and a clear reach the same flag in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pe_i | input | 1 | Peripheral enable |
| ack_en_i | input | 1 | Acknowledge enable, qualifies the address-match pulse |
| ev_btf_i | input | 1 | Byte-done pulse |
| btf_tx_i | input | 1 | Direction of the finished byte, 1 = transmitted |
| btf_clr_i | input | 1 | Byte-done state cleared |
| ev_adsl_i | input | 1 | Slave address matched |
| ev_sb_i | input | 1 | Start generated as master |
| ev_af_i | input | 1 | No acknowledge after a transmitted byte |
| ev_stopf_i | input | 1 | Stop detected as slave |
| ev_arlo_i | input | 1 | Arbitration lost |
| ev_berr_i | input | 1 | Bus error |
| ev_add10_i | input | 1 | 10-bit header byte sent |
| start_det_i | input | 1 | Start condition seen on the bus |
| stop_det_i | input | 1 | Stop condition seen on the bus |
| sr2_rd_i | input | 1 | Secondary status register read strobe |
| dr_wr_i | input | 1 | Data register write strobe |
| acc_other_i | input | 1 | Any other register access strobe |
| status_o | output | 8 | Packed status byte |
| evf_o | output | 1 | Event flag |
| add10_o | output | 1 | Header flag |
| tra_o | output | 1 | Direction flag |
| busy_o | output | 1 | Bus busy flag |

## Verification
The bench targets the choice between the two event-flag clear paths. A design that mixes them up either keeps the event flag set after the software sequence has run or clears it with the wrong access. The bench breaks the header clear sequence with an unrelated access, and with a write that has no read before it. A design with no arm tracking drops the header flag too early. It lines up sets and clears in the same cycle and toggles the enable in the middle of a transfer. This catches a design that loses an event or keeps stale flags, and one whose busy flag wrongly follows the enable.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_EVF  = 7;
  localparam int unsigned BIT_A10  = 6;
  localparam int unsigned BIT_TRA  = 5;
  localparam int unsigned BIT_BUSY = 4;

  typedef struct packed {
    logic btf;
    logic adsl;
    logic sb;
    logic af;
    logic stopf;
    logic arlo;
    logic berr;
    logic add10;
  } ev_t;
endpackage

// File: rtl/i2c_evf_unit.sv
module i2c_evf_unit
  import i2c_stat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pe_i,
  input  logic ack_en_i,
  input  ev_t  ev_i,
  input  logic sr2_rd_i,
  input  logic dr_wr_i,
  output logic evf_o
);
  logic evf_q, err_q, any_set, err_set, clr;

  assign any_set = ev_i.btf | (ev_i.adsl & ack_en_i) | ev_i.sb | ev_i.af |
                   ev_i.stopf | ev_i.arlo | ev_i.berr | ev_i.add10;
  assign err_set = ev_i.af | ev_i.stopf | ev_i.arlo | ev_i.berr;
  // error pending selects which access acknowledges the event
  assign clr     = err_q ? sr2_rd_i : dr_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evf_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!pe_i) begin
      evf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (any_set)  evf_q <= 1'b1;
      else if (clr) evf_q <= 1'b0;
      if (err_set)       err_q <= 1'b1;
      else if (sr2_rd_i) err_q <= 1'b0;
    end
  end

  assign evf_o = evf_q;

  AST_EVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && any_set |=> evf_o); // R3
  AST_EVF_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && err_q && sr2_rd_i && !any_set |=> !evf_o); // R4
  AST_EVF_PE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_i |=> !evf_o); // R8
endmodule

// File: rtl/i2c_add10_unit.sv
module i2c_add10_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pe_i,
  input  logic ev_add10_i,
  input  logic sr2_rd_i,
  input  logic dr_wr_i,
  input  logic acc_other_i,
  output logic add10_o
);
  logic add10_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add10_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (!pe_i) begin
      add10_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ev_add10_i)              add10_q <= 1'b1;
      else if (dr_wr_i && armed_q) add10_q <= 1'b0;
      if (sr2_rd_i)                     armed_q <= 1'b1;
      else if (dr_wr_i || acc_other_i)  armed_q <= 1'b0;
    end
  end

  assign add10_o = add10_q;

  AST_A10_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && ev_add10_i |=> add10_o); // R5
  AST_A10_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && add10_o && !dr_wr_i |=> add10_o); // R5
  AST_A10_PE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_i |=> !add10_o); // R8
endmodule

// File: rtl/i2c_tra_busy_unit.sv
module i2c_tra_busy_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pe_i,
  input  logic ev_btf_i,
  input  logic btf_tx_i,
  input  logic btf_clr_i,
  input  logic ev_stopf_i,
  input  logic ev_arlo_i,
  input  logic ev_berr_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  output logic tra_o,
  output logic busy_o
);
  logic tra_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tra_q <= 1'b0;
    else if (!pe_i)    tra_q <= 1'b0;
    else if (ev_btf_i) tra_q <= btf_tx_i;
    else if (btf_clr_i || ev_stopf_i || ev_arlo_i) tra_q <= 1'b0;
  end

  // bus activity tracks line conditions regardless of enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        busy_q <= 1'b0;
    else if (start_det_i)               busy_q <= 1'b1;
    else if (stop_det_i || ev_berr_i)   busy_q <= 1'b0;
  end

  assign tra_o  = tra_q;
  assign busy_o = busy_q;

  AST_TRA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && ev_btf_i |=> tra_o == $past(btf_tx_i)); // R6
  AST_TRA_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i && !ev_btf_i && (ev_stopf_i || ev_arlo_i) |=> !tra_o); // R6
  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> busy_o); // R9
  AST_BUSY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_det_i && (stop_det_i || ev_berr_i) |=> !busy_o); // R7
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pe_i,
  input  logic              ack_en_i,
  input  logic              ev_btf_i,
  input  logic              btf_tx_i,
  input  logic              btf_clr_i,
  input  logic              ev_adsl_i,
  input  logic              ev_sb_i,
  input  logic              ev_af_i,
  input  logic              ev_stopf_i,
  input  logic              ev_arlo_i,
  input  logic              ev_berr_i,
  input  logic              ev_add10_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              sr2_rd_i,
  input  logic              dr_wr_i,
  input  logic              acc_other_i,
  output logic [STAT_W-1:0] status_o,
  output logic              evf_o,
  output logic              add10_o,
  output logic              tra_o,
  output logic              busy_o
);
  ev_t ev;

  assign ev = '{btf: ev_btf_i, adsl: ev_adsl_i, sb: ev_sb_i, af: ev_af_i,
                stopf: ev_stopf_i, arlo: ev_arlo_i, berr: ev_berr_i,
                add10: ev_add10_i};

  i2c_evf_unit u_evf (
    .clk_i, .rst_ni, .pe_i, .ack_en_i, .ev_i(ev),
    .sr2_rd_i, .dr_wr_i, .evf_o
  );

  i2c_add10_unit u_add10 (
    .clk_i, .rst_ni, .pe_i, .ev_add10_i, .sr2_rd_i, .dr_wr_i,
    .acc_other_i, .add10_o
  );

  i2c_tra_busy_unit u_tb (
    .clk_i, .rst_ni, .pe_i, .ev_btf_i, .btf_tx_i, .btf_clr_i,
    .ev_stopf_i, .ev_arlo_i, .ev_berr_i, .start_det_i, .stop_det_i,
    .tra_o, .busy_o
  );

  always_comb begin
    status_o           = '0;
    status_o[BIT_EVF]  = evf_o;
    status_o[BIT_A10]  = add10_o;
    status_o[BIT_TRA]  = tra_o;
    status_o[BIT_BUSY] = busy_o;
  end

  AST_EVF_NOSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evf_o && !(ev_btf_i || (ev_adsl_i && ack_en_i) || ev_sb_i || ev_af_i ||
      ev_stopf_i || ev_arlo_i || ev_berr_i || ev_add10_i) |=> !evf_o); // R3
  AST_A10_NOSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add10_o && !ev_add10_i |=> !add10_o); // R5
endmodule

// File: tb/i2c_stat_flags_tb_top.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pe_i, ack_en_i, ev_btf_i, btf_tx_i, btf_clr_i, ev_adsl_i, ev_sb_i;
  logic ev_af_i, ev_stopf_i, ev_arlo_i, ev_berr_i, ev_add10_i;
  logic start_det_i, stop_det_i, sr2_rd_i, dr_wr_i, acc_other_i;
  logic [7:0] status_o;
  logic evf_o, add10_o, tra_o, busy_o;

  int n_chk = 0, n_err = 0;
  bit m_evf, m_err, m_a10, m_arm, m_tra, m_busy;

  always #2.5 clk_i = ~clk_i;

  i2c_stat_flags dut_i (.*);

  function automatic logic [7:0] exp_byte();
    return {m_evf, m_a10, m_tra, m_busy, 4'h0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_btf_i = 0; btf_tx_i = 0; btf_clr_i = 0; ev_adsl_i = 0; ev_sb_i = 0;
    ev_af_i = 0; ev_stopf_i = 0; ev_arlo_i = 0; ev_berr_i = 0; ev_add10_i = 0;
    start_det_i = 0; stop_det_i = 0; sr2_rd_i = 0; dr_wr_i = 0; acc_other_i = 0;
  endtask

  task automatic model();
    bit any, errs, nevf, nerr, na10, narm, ntra, nbusy;
    any  = ev_btf_i | (ev_adsl_i & ack_en_i) | ev_sb_i | ev_af_i | ev_stopf_i |
           ev_arlo_i | ev_berr_i | ev_add10_i;
    errs = ev_af_i | ev_stopf_i | ev_arlo_i | ev_berr_i;
    nevf = m_evf; nerr = m_err; na10 = m_a10; narm = m_arm; ntra = m_tra;
    if (!pe_i) begin
      nevf = 0; nerr = 0; na10 = 0; narm = 0; ntra = 0;
    end else begin
      if (any) nevf = 1;
      else if (m_err ? sr2_rd_i : dr_wr_i) nevf = 0;
      if (errs) nerr = 1; else if (sr2_rd_i) nerr = 0;
      if (ev_add10_i) na10 = 1; else if (dr_wr_i && m_arm) na10 = 0;
      if (sr2_rd_i) narm = 1; else if (dr_wr_i || acc_other_i) narm = 0;
      if (ev_btf_i) ntra = btf_tx_i;
      else if (btf_clr_i || ev_stopf_i || ev_arlo_i) ntra = 0;
    end
    nbusy = m_busy;
    if (start_det_i) nbusy = 1; else if (stop_det_i || ev_berr_i) nbusy = 0;
    m_evf = nevf; m_err = nerr; m_a10 = na10; m_arm = narm;
    m_tra = ntra; m_busy = nbusy;
  endtask

  // one clock: model next state, advance, check whole byte and pins, release pulses
  task automatic cyc(string tag);
    model();
    @(posedge clk_i); #1;
    chk(tag, status_o, exp_byte());
    chk({tag, " R2 pins"}, {evf_o, add10_o, tra_o, busy_o, 4'h0}, status_o);
    idle();
  endtask

  initial begin
    pe_i = 0; ack_en_i = 1; idle();
    m_evf = 0; m_err = 0; m_a10 = 0; m_arm = 0; m_tra = 0; m_busy = 0;
    void'($urandom(32'h1c2a));
    #12; chk("R1 reset", status_o, 8'h00);
    @(negedge clk_i); rst_ni = 1; pe_i = 1;
    cyc("R1 idle");
    // R3 address match without ack enable
    ack_en_i = 0; ev_adsl_i = 1; cyc("R3 adsl noack");
    chk("R3 adsl noack evf", {7'b0, evf_o}, 8'h00);
    ack_en_i = 1; ev_adsl_i = 1; cyc("R3 adsl ack");
    chk("R3 adsl evf", {7'b0, evf_o}, 8'h01);
    // R4 non-error: sr2 read does not clear, write does
    sr2_rd_i = 1; cyc("R4 sr2 no err");
    chk("R4 sr2 keeps evf", {7'b0, evf_o}, 8'h01);
    dr_wr_i = 1; cyc("R4 dr clears");
    chk("R4 evf cleared", {7'b0, evf_o}, 8'h00);
    // R4 error path
    ev_af_i = 1; cyc("R4 af");
    dr_wr_i = 1; cyc("R4 dr no clear err");
    chk("R4 evf held", {7'b0, evf_o}, 8'h01);
    sr2_rd_i = 1; cyc("R4 sr2 clears err");
    chk("R4 evf cleared err", {7'b0, evf_o}, 8'h00);
    // R5 header sequence broken by other access
    ev_add10_i = 1; cyc("R5 set");
    sr2_rd_i = 1; cyc("R5 arm");
    acc_other_i = 1; cyc("R5 disarm");
    dr_wr_i = 1; cyc("R5 write unarmed");
    chk("R5 a10 kept", {7'b0, add10_o}, 8'h01);
    sr2_rd_i = 1; cyc("R5 rearm");
    dr_wr_i = 1; cyc("R5 clear");
    chk("R5 a10 cleared", {7'b0, add10_o}, 8'h00);
    // R6 direction
    ev_btf_i = 1; btf_tx_i = 1; cyc("R6 tx");
    chk("R6 tra tx", {7'b0, tra_o}, 8'h01);
    btf_clr_i = 1; cyc("R6 btf clr");
    ev_btf_i = 1; btf_tx_i = 1; cyc("R6 tx2");
    ev_arlo_i = 1; cyc("R6 arlo clr");
    chk("R6 tra arlo", {7'b0, tra_o}, 8'h00);
    // R9 set wins
    ev_btf_i = 1; btf_tx_i = 1; ev_stopf_i = 1; cyc("R9 tra set wins");
    chk("R9 tra", {7'b0, tra_o}, 8'h01);
    start_det_i = 1; stop_det_i = 1; cyc("R9 busy set wins");
    chk("R9 busy", {7'b0, busy_o}, 8'h01);
    sr2_rd_i = 1; ev_sb_i = 1; cyc("R9 evf set wins");
    // R7 busy independent of enable, bus error clears
    pe_i = 0; cyc("R8 pe off");
    chk("R8 flags clear", status_o, 8'h10);
    ev_btf_i = 1; btf_tx_i = 1; ev_add10_i = 1; ev_sb_i = 1; cyc("R8 ignore");
    chk("R8 ignored", status_o, 8'h10);
    ev_berr_i = 1; cyc("R7 berr clr busy");
    chk("R7 busy off", {7'b0, busy_o}, 8'h00);
    start_det_i = 1; cyc("R7 start pe off");
    pe_i = 1; stop_det_i = 1; cyc("R7 stop");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      pe_i       = ($urandom % 16) != 0;
      ack_en_i   = $urandom % 2;
      ev_btf_i   = ($urandom % 6) == 0; btf_tx_i = $urandom % 2;
      btf_clr_i  = ($urandom % 6) == 0;
      ev_adsl_i  = ($urandom % 10) == 0; ev_sb_i = ($urandom % 10) == 0;
      ev_af_i    = ($urandom % 12) == 0; ev_stopf_i = ($urandom % 12) == 0;
      ev_arlo_i  = ($urandom % 14) == 0; ev_berr_i = ($urandom % 16) == 0;
      ev_add10_i = ($urandom % 10) == 0;
      start_det_i = ($urandom % 8) == 0; stop_det_i = ($urandom % 8) == 0;
      sr2_rd_i   = ($urandom % 4) == 0; dr_wr_i = ($urandom % 4) == 0;
      acc_other_i = ($urandom % 8) == 0;
      cyc("R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule